// File: doc/BRIEF.md
# Frame Buffer Scanout Controller

The block turns a true-colour image in memory into a live video stream for a TFT panel or VGA output. A two-entry register file holds a frame base address and a control word with an enable flag and a 180-degree rotate flag. A raster timing generator walks every clock position of the frame. For each visible position the block issues a word read request on a simple memory read port with a valid/ready handshake. The memory answers after a fixed number of cycles. The returned word is split into 8-bit red, green and blue and driven out, aligned with the horizontal sync, vertical sync and data-enable outputs.

Each pixel is one 32-bit word. Each image row occupies a fixed stride of words. Only the leading visible words of a row are fetched. Base address and rotation are sampled once per frame, so a frame never mixes two settings. The enable flag acts on the next cycle. All sizes, the timing and the read latency are parameters. The defaults give a 640x480 picture with a 1024-word stride, 800 clocks per line and 525 lines per frame.

Top module: `fbscan_top`

## Requirements
- R1: After reset both registers read zero, no read request is issued and the colour outputs are zero.
- R2: Register index 0 keeps only the top BASE_KEEP (11) bits of a written value and reads the lower bits as zero. Register index 1 keeps bit 0 (enable) and bit 1 (rotate) and reads every other bit as zero.
- R3: While enable is 0, `rd_req_valid` stays low and the colour outputs stay zero, while syncs keep running.
- R4: In normal order, the request at visible position (x, y) carries word address base/4 + y*ROW_WORDS + x, in raster order.
- R5: With rotate set, the request at visible position (x, y) carries word address base/4 + (V_ACT-1-y)*ROW_WORDS + (H_ACT-1-x), so scanout starts at the last pixel of the last row and runs backward.
- R6: From an accepted word, bits 23:16 drive red, 15:8 drive green and 7:0 drive blue, and bits 31:24 have no effect.
- R7: A request made in cycle t appears on the outputs in cycle t+RD_LAT+1, with `vid_de` high in that same cycle.
- R8: A visible position whose request is not accepted (ready low) is shown as black.
- R9: A line lasts H_ACT+H_FP+H_SY+H_BP clocks. `vid_hsync_n` is low for H_SY clocks starting H_ACT+H_FP clocks into the line. A frame lasts V_ACT+V_FP+V_SY+V_BP lines, with `vid_vsync_n` low for V_SY lines after V_ACT+V_FP lines. `vid_de` is high only on the first H_ACT clocks of the first V_ACT lines, and colour outputs are zero whenever `vid_de` is low.
- R10: A new base address or rotate value written during a frame takes effect at the start of the following frame.
- R11: Word columns H_ACT to ROW_WORDS-1 of any row are never requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_idx | input | 1 | Write index: 0 base, 1 control |
| reg_wr_data | input | DW | Write data |
| reg_rd_idx | input | 1 | Read index: 0 base, 1 control |
| reg_rd_data | output | DW | Read data for `reg_rd_idx` |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | DW-2 | Word address of the request |
| rd_data | input | DW | Pixel word, RD_LAT cycles after acceptance |
| vid_r | output | 8 | Red |
| vid_g | output | 8 | Green |
| vid_b | output | 8 | Blue |
| vid_hsync_n | output | 1 | Horizontal sync, active low |
| vid_vsync_n | output | 1 | Vertical sync, active low |
| vid_de | output | 1 | Data enable |

## Verification
The bench builds the block with an 8x4 visible area, a 16-word row stride, 16 clocks per line, 8 lines per frame and a read latency of 2. With these values a whole frame takes 128 cycles. Several complete frames therefore fit in a short run, including the porch and sync regions, the frame wrap, and a settings change in the middle of a frame. The stride is still wider than the visible row, so the unfetched columns and the rotated address arithmetic are exercised in the same way as at full size.

// File: rtl/fbscan_pkg.sv
package fbscan_pkg;
   localparam int REG_IDX_BASE = 0;
   localparam int REG_IDX_CTRL = 1;
   localparam int CTRL_BIT_EN  = 0;
   localparam int CTRL_BIT_ROT = 1;

   // one raster position's display qualifiers
   typedef struct packed {
      logic de;
      logic hs_n;
      logic vs_n;
   } beat_t;
endpackage

// File: rtl/fbscan_timing.sv
module fbscan_timing
   import fbscan_pkg::*;
#(
   parameter int H_ACT = 640,
   parameter int H_FP  = 16,
   parameter int H_SY  = 96,
   parameter int H_BP  = 48,
   parameter int V_ACT = 480,
   parameter int V_FP  = 10,
   parameter int V_SY  = 2,
   parameter int V_BP  = 33,
   parameter int HCW   = 10,
   parameter int VCW   = 10
) (
   input  logic           clk,
   input  logic           rst_n,
   output logic [HCW-1:0] hcnt,
   output logic [VCW-1:0] vcnt,
   output beat_t          beat,
   output logic           frame_end
);
   localparam int H_TOT = H_ACT + H_FP + H_SY + H_BP;
   localparam int V_TOT = V_ACT + V_FP + V_SY + V_BP;

   if (H_TOT > (1 << HCW)) begin : g_err_hcw
      $error("horizontal counter too narrow");
   end
   if (V_TOT > (1 << VCW)) begin : g_err_vcw
      $error("vertical counter too narrow");
   end

   logic line_end;
   assign line_end  = (hcnt == HCW'(H_TOT - 1));
   assign frame_end = line_end && (vcnt == VCW'(V_TOT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt <= '0;
         vcnt <= '0;
      end else if (line_end) begin
         hcnt <= '0;
         vcnt <= frame_end ? '0 : vcnt + 1'b1;
      end else begin
         hcnt <= hcnt + 1'b1;
      end
   end

   always_comb begin
      beat.de   = (hcnt < HCW'(H_ACT)) && (vcnt < VCW'(V_ACT));
      beat.hs_n = !((hcnt >= HCW'(H_ACT + H_FP)) && (hcnt < HCW'(H_ACT + H_FP + H_SY)));
      beat.vs_n = !((vcnt >= VCW'(V_ACT + V_FP)) && (vcnt < VCW'(V_ACT + V_FP + V_SY)));
   end

   assert_hcnt_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hcnt <= HCW'(H_TOT - 1));
   assert_line_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (vcnt != $past(vcnt)) |-> ($past(hcnt) == HCW'(H_TOT - 1)));
endmodule

// File: rtl/fbscan_regs.sv
module fbscan_regs
   import fbscan_pkg::*;
#(
   parameter int DW        = 32,
   parameter int BASE_KEEP = 11
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 wr_idx,
   input  logic [DW-1:0]        wr_data,
   input  logic                 rd_idx,
   input  logic                 frame_end,
   output logic [DW-1:0]        rd_data,
   output logic                 en_live,
   output logic [BASE_KEEP-1:0] base_frame,
   output logic                 rot_frame
);
   if (BASE_KEEP >= DW || BASE_KEEP < 1) begin : g_err_keep
      $error("BASE_KEEP out of range");
   end

   logic [BASE_KEEP-1:0] base_q;
   logic                 rot_q;
   logic                 unused_wr_bits;
   assign unused_wr_bits = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q     <= '0;
         rot_q      <= 1'b0;
         en_live    <= 1'b0;
         base_frame <= '0;
         rot_frame  <= 1'b0;
      end else begin
         if (wr_en && wr_idx == 1'(REG_IDX_BASE))
            base_q <= wr_data[DW-1 -: BASE_KEEP];
         if (wr_en && wr_idx == 1'(REG_IDX_CTRL)) begin
            en_live <= wr_data[CTRL_BIT_EN];
            rot_q   <= wr_data[CTRL_BIT_ROT];
         end
         // frame-wide settings move only across the frame boundary
         if (frame_end) begin
            base_frame <= base_q;
            rot_frame  <= rot_q;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_idx == 1'(REG_IDX_CTRL)) begin
         rd_data[CTRL_BIT_EN]  = en_live;
         rd_data[CTRL_BIT_ROT] = rot_q;
      end else begin
         rd_data[DW-1 -: BASE_KEEP] = base_q;
      end
   end

   assert_ctrl_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == 1'(REG_IDX_CTRL)) |=>
         ({rot_q, en_live} == {$past(wr_data[CTRL_BIT_ROT]), $past(wr_data[CTRL_BIT_EN])}));
   assert_frame_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((base_frame != $past(base_frame)) || (rot_frame != $past(rot_frame))) |-> $past(frame_end));
endmodule

// File: rtl/fbscan_addr.sv
module fbscan_addr #(
   parameter int H_ACT     = 640,
   parameter int V_ACT     = 480,
   parameter int ROW_WORDS = 1024,
   parameter int AW        = 30,
   parameter int BASE_KEEP = 11,
   parameter int HCW       = 10,
   parameter int VCW       = 10
) (
   input  logic [HCW-1:0]       hcnt,
   input  logic [VCW-1:0]       vcnt,
   input  logic [BASE_KEEP-1:0] base_frame,
   input  logic                 rot_frame,
   output logic [AW-1:0]        addr
);
   localparam int XW = $clog2(ROW_WORDS);

   logic [AW-1:0] x_w, y_w, x_eff, y_eff, base_w;

   always_comb begin
      x_w    = AW'(hcnt);
      y_w    = AW'(vcnt);
      // reversed scan mirrors both coordinates about the visible area
      x_eff  = rot_frame ? AW'(H_ACT - 1) - x_w : x_w;
      y_eff  = rot_frame ? AW'(V_ACT - 1) - y_w : y_w;
      base_w = {base_frame, {(AW - BASE_KEEP){1'b0}}};
      addr   = base_w + (y_eff << XW) + x_eff;
   end
endmodule

// File: rtl/fbscan_pixel.sv
module fbscan_pixel
   import fbscan_pkg::*;
#(
   parameter int LAT = 2,
   parameter int CW  = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  beat_t           beat_in,
   input  logic            accept,
   input  logic [3*CW-1:0] pix_in,
   output logic [CW-1:0]   vid_r,
   output logic [CW-1:0]   vid_g,
   output logic [CW-1:0]   vid_b,
   output logic            vid_de,
   output logic            vid_hsync_n,
   output logic            vid_vsync_n
);
   if (LAT < 1) begin : g_err_lat
      $error("read latency must be at least one cycle");
   end

   localparam beat_t IDLE = '{de: 1'b0, hs_n: 1'b1, vs_n: 1'b1};

   beat_t beat_pipe [LAT];
   logic  acc_pipe  [LAT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < LAT; k++) begin
            beat_pipe[k] <= IDLE;
            acc_pipe[k]  <= 1'b0;
         end
         vid_de      <= 1'b0;
         vid_hsync_n <= 1'b1;
         vid_vsync_n <= 1'b1;
         {vid_r, vid_g, vid_b} <= '0;
      end else begin
         beat_pipe[0] <= beat_in;
         acc_pipe[0]  <= accept;
         for (int k = 1; k < LAT; k++) begin
            beat_pipe[k] <= beat_pipe[k-1];
            acc_pipe[k]  <= acc_pipe[k-1];
         end
         vid_de      <= beat_pipe[LAT-1].de;
         vid_hsync_n <= beat_pipe[LAT-1].hs_n;
         vid_vsync_n <= beat_pipe[LAT-1].vs_n;
         {vid_r, vid_g, vid_b} <= acc_pipe[LAT-1] ? pix_in : '0;
      end
   end

   assert_black_outside_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !vid_de |-> ({vid_r, vid_g, vid_b} == '0));
endmodule

// File: rtl/fbscan_top.sv
module fbscan_top
   import fbscan_pkg::*;
#(
   parameter int DW        = 32,
   parameter int BASE_KEEP = 11,
   parameter int H_ACT     = 640,
   parameter int H_FP      = 16,
   parameter int H_SY      = 96,
   parameter int H_BP      = 48,
   parameter int V_ACT     = 480,
   parameter int V_FP      = 10,
   parameter int V_SY      = 2,
   parameter int V_BP      = 33,
   parameter int ROW_WORDS = 1024,
   parameter int RD_LAT    = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr_en,
   input  logic          reg_wr_idx,
   input  logic [DW-1:0] reg_wr_data,
   input  logic          reg_rd_idx,
   output logic [DW-1:0] reg_rd_data,
   output logic          rd_req_valid,
   input  logic          rd_req_ready,
   output logic [DW-3:0] rd_req_addr,
   input  logic [DW-1:0] rd_data,
   output logic [7:0]    vid_r,
   output logic [7:0]    vid_g,
   output logic [7:0]    vid_b,
   output logic          vid_hsync_n,
   output logic          vid_vsync_n,
   output logic          vid_de
);
   localparam int AW    = DW - 2;
   localparam int H_TOT = H_ACT + H_FP + H_SY + H_BP;
   localparam int V_TOT = V_ACT + V_FP + V_SY + V_BP;
   localparam int HCW   = $clog2(H_TOT);
   localparam int VCW   = $clog2(V_TOT);
   localparam int XW    = $clog2(ROW_WORDS);

   if (ROW_WORDS != (1 << XW)) begin : g_err_stride_pow2
      $error("row stride must be a power of two");
   end
   if (ROW_WORDS < H_ACT) begin : g_err_stride_short
      $error("row stride shorter than visible row");
   end
   if (longint'(V_ACT) * ROW_WORDS > (longint'(1) << (AW - BASE_KEEP))) begin : g_err_align
      $error("frame does not fit below base alignment");
   end
   if (DW < 26) begin : g_err_dw
      $error("data width too small for a 24-bit pixel");
   end

   logic [HCW-1:0]       hcnt;
   logic [VCW-1:0]       vcnt;
   beat_t                beat;
   logic                 frame_end;
   logic                 en_live;
   logic [BASE_KEEP-1:0] base_frame;
   logic                 rot_frame;
   logic                 accept;
   logic                 unused_top_byte;

   assign unused_top_byte = ^rd_data[DW-1:24];

   fbscan_timing #(
      .H_ACT(H_ACT), .H_FP(H_FP), .H_SY(H_SY), .H_BP(H_BP),
      .V_ACT(V_ACT), .V_FP(V_FP), .V_SY(V_SY), .V_BP(V_BP),
      .HCW(HCW), .VCW(VCW)
   ) i_timing (
      .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt),
      .beat(beat), .frame_end(frame_end)
   );

   fbscan_regs #(.DW(DW), .BASE_KEEP(BASE_KEEP)) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_idx(reg_wr_idx),
      .wr_data(reg_wr_data), .rd_idx(reg_rd_idx), .frame_end(frame_end),
      .rd_data(reg_rd_data), .en_live(en_live), .base_frame(base_frame),
      .rot_frame(rot_frame)
   );

   fbscan_addr #(
      .H_ACT(H_ACT), .V_ACT(V_ACT), .ROW_WORDS(ROW_WORDS), .AW(AW),
      .BASE_KEEP(BASE_KEEP), .HCW(HCW), .VCW(VCW)
   ) i_addr (
      .hcnt(hcnt), .vcnt(vcnt), .base_frame(base_frame),
      .rot_frame(rot_frame), .addr(rd_req_addr)
   );

   assign rd_req_valid = en_live && beat.de;
   assign accept       = rd_req_valid && rd_req_ready;

   fbscan_pixel #(.LAT(RD_LAT), .CW(8)) i_pixel (
      .clk(clk), .rst_n(rst_n), .beat_in(beat), .accept(accept),
      .pix_in(rd_data[23:0]), .vid_r(vid_r), .vid_g(vid_g), .vid_b(vid_b),
      .vid_de(vid_de), .vid_hsync_n(vid_hsync_n), .vid_vsync_n(vid_vsync_n)
   );

   assert_unfetched_cols_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_valid |-> ({1'b0, rd_req_addr[XW-1:0]} < (XW+1)'(H_ACT)));
endmodule

// File: tb/test_fbscan_top.sv
module test_fbscan_top;
   localparam int HA = 8, HF = 2, HS = 3, HB = 3, HT = HA + HF + HS + HB;
   localparam int VA = 4, VF = 1, VS = 2, VB = 1, VT = VA + VF + VS + VB;
   localparam int STR = 16, LAT = 2, FR = HT * VT, BSH = 19;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_wr_en, reg_wr_idx, reg_rd_idx;
   logic [31:0] reg_wr_data, reg_rd_data, rd_data;
   logic        rd_req_valid, rd_req_ready;
   logic [29:0] rd_req_addr;
   logic [7:0]  vid_r, vid_g, vid_b;
   logic        vid_hsync_n, vid_vsync_n, vid_de;

   int checks = 0, failures = 0, cyc;

   always #10 clk = ~clk;

   fbscan_top #(
      .H_ACT(HA), .H_FP(HF), .H_SY(HS), .H_BP(HB),
      .V_ACT(VA), .V_FP(VF), .V_SY(VS), .V_BP(VB),
      .ROW_WORDS(STR), .RD_LAT(LAT)
   ) i_fbscan_top (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx),
      .reg_wr_data(reg_wr_data), .reg_rd_idx(reg_rd_idx), .reg_rd_data(reg_rd_data),
      .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
      .rd_req_addr(rd_req_addr), .rd_data(rd_data), .vid_r(vid_r), .vid_g(vid_g),
      .vid_b(vid_b), .vid_hsync_n(vid_hsync_n), .vid_vsync_n(vid_vsync_n), .vid_de(vid_de)
   );

   function automatic logic [31:0] pix_of(input logic [29:0] a);
      return {8'hEE, a[7:0] ^ 8'h5A, a[29:22] ^ a[7:0], a[7:0] + 8'd1};
   endfunction
   function automatic int hpos(input int c); return c % HT; endfunction
   function automatic int vpos(input int c); return (c / HT) % VT; endfunction
   function automatic bit act(input int c);
      return hpos(c) < HA && vpos(c) < VA;
   endfunction
   function automatic bit hsn(input int c);
      return !(hpos(c) >= HA + HF && hpos(c) < HA + HF + HS);
   endfunction
   function automatic bit vsn(input int c);
      return !(vpos(c) >= VA + VF && vpos(c) < VA + VF + VS);
   endfunction
   function automatic logic [29:0] exp_addr(input int c, input int btop, input bit rot);
      longint x = rot ? HA - 1 - hpos(c) : hpos(c);
      longint y = rot ? VA - 1 - vpos(c) : vpos(c);
      return 30'((longint'(btop) << BSH) + y * STR + x);
   endfunction

   // memory model: fixed latency answer
   logic        mv [LAT];
   logic [29:0] ma [LAT];
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < LAT; i++) begin mv[i] <= 1'b0; ma[i] <= '0; end
      end else begin
         mv[0] <= rd_req_valid && rd_req_ready;
         ma[0] <= rd_req_addr;
         for (int i = 1; i < LAT; i++) begin mv[i] <= mv[i-1]; ma[i] <= ma[i-1]; end
      end
   end
   assign rd_data = mv[LAT-1] ? pix_of(ma[LAT-1]) : 32'hC3C3_C3C3;

   always @(posedge clk or negedge rst_n)
      if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

   logic        ring_acc  [8];
   logic [29:0] ring_addr [8];
   initial for (int i = 0; i < 8; i++) begin ring_acc[i] = 1'b0; ring_addr[i] = '0; end
   always @(posedge clk) if (rst_n) begin
      ring_acc[cyc % 8]  <= rd_req_valid && rd_req_ready;
      ring_addr[cyc % 8] <= rd_req_addr;
   end

   task automatic check(input bit ok, input string tag, input longint actv, input longint expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, actv, expv, cyc);
      end
   endtask

   task automatic wr(input bit idx, input logic [31:0] d);
      reg_wr_en = 1'b1; reg_wr_idx = idx; reg_wr_data = d;
      @(posedge clk); #1;
      reg_wr_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic rd_check(input bit idx, input logic [31:0] expv, input string tag);
      reg_rd_idx = idx; #1;
      check(reg_rd_data == expv, tag, reg_rd_data, expv);
   endtask

   task automatic wait_frame_start();
      while (cyc % FR != 0) @(negedge clk);
   endtask

   // one cycle of checks; positioned just after a negedge
   task automatic do_cycle(input int btop, input bit rot, input bit en, input int mode, input string atag);
      int c = cyc;
      int s = c - LAT - 1;
      bit ev;
      logic [23:0] er;
      rd_req_ready = (mode == 0) ? 1'b1 : (hpos(c) % 3 != 1);
      #1;
      ev = en && act(c);
      check(rd_req_valid == ev, en ? "R4 valid" : "R3 no request", rd_req_valid, ev);
      if (ev) begin
         check(rd_req_addr == exp_addr(c, btop, rot),
               atag != "" ? atag : (rot ? "R5 address" : "R4 address"),
               rd_req_addr, exp_addr(c, btop, rot));
         check(rd_req_addr[3:0] < HA, "R11 column", rd_req_addr[3:0], HA - 1);
      end
      if (s >= 0) begin
         check(vid_de == act(s), "R7 de alignment", vid_de, act(s));
         check(vid_hsync_n == hsn(s), "R9 hsync", vid_hsync_n, hsn(s));
         check(vid_vsync_n == vsn(s), "R9 vsync", vid_vsync_n, vsn(s));
         er = ring_acc[s % 8] ? pix_of(ring_addr[s % 8])[23:0] : 24'h0;
         check({vid_r, vid_g, vid_b} == er,
               mode != 0 ? "R8 colour" : (en ? "R6 colour" : "R3 black"),
               {vid_r, vid_g, vid_b}, er);
      end
   endtask

   task automatic check_span(input int n, input int btop, input bit rot, input bit en,
                             input int mode, input string atag);
      repeat (n) begin
         do_cycle(btop, rot, en, mode, atag);
         @(negedge clk);
      end
      rd_req_ready = 1'b1;
   endtask

   task automatic t_reset();  // R1
      rd_check(1'b0, 32'h0, "R1 base after reset");
      rd_check(1'b1, 32'h0, "R1 ctrl after reset");
      check(rd_req_valid == 1'b0, "R1 no request", rd_req_valid, 0);
      check({vid_r, vid_g, vid_b} == 24'h0, "R1 black", {vid_r, vid_g, vid_b}, 0);
   endtask

   task automatic t_regs();  // R2
      wr(1'b0, 32'hFFFF_FFFF);
      rd_check(1'b0, 32'hFFE0_0000, "R2 base keeps top bits");
      wr(1'b1, 32'hFFFF_FFFC);
      rd_check(1'b1, 32'h0, "R2 ctrl ignores upper bits");
      wr(1'b1, 32'h0000_0002);
      rd_check(1'b1, 32'h2, "R2 ctrl rotate bit");
      wr(1'b0, 32'h0060_1234);
      rd_check(1'b0, 32'h0060_0000, "R2 base low bits zero");
      wr(1'b1, 32'h0);
   endtask

   task automatic t_disabled();  // R3, R9
      wait_frame_start();
      check_span(FR, 3, 1'b0, 1'b0, 0, "");
   endtask

   task automatic t_normal();  // R4, R6, R7, R11
      wr(1'b1, 32'h1);
      wait_frame_start();
      check_span(FR, 3, 1'b0, 1'b1, 0, "");
   endtask

   task automatic t_rotate();  // R5
      wr(1'b1, 32'h3);
      wait_frame_start();
      check_span(FR, 3, 1'b1, 1'b1, 0, "");
   endtask

   task automatic t_backpressure();  // R8
      wr(1'b0, 32'h0A00_0000);
      wr(1'b1, 32'h1);
      wait_frame_start();
      check_span(FR, 'h50, 1'b0, 1'b1, 1, "");
   endtask

   task automatic t_midframe();  // R10
      wait_frame_start();
      check_span(40, 'h50, 1'b0, 1'b1, 0, "R10 before change");
      wr(1'b0, 32'h1FE0_0000);
      wr(1'b1, 32'h3);
      check_span(FR - (cyc % FR), 'h50, 1'b0, 1'b1, 0, "R10 old settings hold");
      check_span(FR, 'hFF, 1'b1, 1'b1, 0, "R10 new settings");
   endtask

   initial begin
      rst_n = 1'b0; reg_wr_en = 1'b0; reg_wr_idx = 1'b0; reg_wr_data = '0;
      reg_rd_idx = 1'b0; rd_req_ready = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_disabled();
      t_normal();
      t_rotate();
      t_backpressure();
      t_midframe();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule